// File: doc/BRIEF.md
# Serial Audio Output Transmitter

This block sends one stereo pair of 24-bit two's-complement samples per frame out of a single serial data pin. It is a clock slave: the bit clock and the channel clock both come from outside and are oversampled by a faster fabric clock. The data pin is updated only after a falling bit-clock edge, or on a channel-clock transition. A receiver can therefore sample it on the rising edge.

Two framings are available. In left-justified framing the MSB appears together with the channel-clock transition. In I2S framing the MSB is delayed by one bit clock. The framing comes from a two-bit code that is shared with the input side of the system.

A new pair is taken at the start of every left-channel slot. Bits are sent MSB first. Any bit times in a slot beyond the 24th carry zeros.

Top module: `audio_serial_tx`

## Requirements
- R1: While `rst` is high and after it is released, with no clock activity, `sdout` is 0.
- R2: Framing code `fmt_sel` = 2'b01 selects I2S framing. The codes 2'b00, 2'b10 and the unused code 2'b11 all select left-justified framing.
- R3: In left-justified framing the MSB (bit 23) is driven on `sdout` in response to the `sf_in` transition that opens a slot. It is not tied to any bit-clock edge.
- R4: In I2S framing the MSB is driven after the first falling `sc_in` edge that follows the `sf_in` transition. A falling edge seen in the same sampling cycle as the transition still belongs to the previous slot.
- R5: Samples leave MSB first, bit 23 down to bit 0, one bit per falling `sc_in` edge, with the two's-complement value unchanged.
- R6: In left-justified framing `sf_in` high marks the left channel. In I2S framing `sf_in` low marks the left channel.
- R7: When a slot is longer than the number of data bits sent in it, `sdout` is 0 for every remaining bit time.
- R8: `left_smp` is taken when a left slot opens, and `right_smp` is captured at that same moment for the right slot of the frame. Writes made during a frame appear only in the next frame.
- R9: `sdout` changes only shortly after a falling `sc_in` edge or an `sf_in` transition. It is the same just after and just before each rising `sc_in` edge.
- R10: In I2S framing with 24-clock slots, the LSB of a slot occupies the first bit time of the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| sc_in | input | 1 | External bit clock |
| sf_in | input | 1 | External channel clock |
| fmt_sel | input | 2 | Framing code (01 = I2S, others left-justified) |
| left_smp | input | 24 | Left sample, two's complement |
| right_smp | input | 24 | Right sample, two's complement |
| sdout | output | 1 | Serial data output |

## Verification
The bench uses the defaults: a 24-bit sample width and a two-stage synchronizer. The bit clock runs at eight fabric cycles per half period, so the synchronizer and output register settle well inside each half. Slot lengths of 24, 25 and 32 bit clocks are driven. This covers the exact-fit case where the I2S LSB spills into the next slot, as well as the zero-filled tails in both framings. All four framing codes are used, and mode changes force a filler slot so that each framing starts on a left slot. Sample changes are made halfway through a left slot to show the one-frame delay.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic {
    FRAME_LEFTJ = 1'b0,
    FRAME_I2S   = 1'b1
  } frame_e;

  // Only code 01 selects I2S; every other code falls back to left-justified
  function automatic frame_e decode_frame(input logic [1:0] code);
    return (code == 2'b01) ? FRAME_I2S : FRAME_LEFTJ;
  endfunction

endpackage

// File: rtl/tx_edge_sync.sv
module tx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sc_in,
  input  logic sf_in,
  output logic sc_fall,
  output logic sc_rise,
  output logic sf_edge,
  output logic sf_level
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sc_chain;
  logic [STAGES-1:0] sf_chain;
  logic              sc_last;
  logic              sf_last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sc_chain <= '0;
          sf_chain <= '0;
        end else begin
          sc_chain[0] <= sc_in;
          sf_chain[0] <= sf_in;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          sc_chain <= '0;
          sf_chain <= '0;
        end else begin
          sc_chain <= {sc_chain[STAGES-2:0], sc_in};
          sf_chain <= {sf_chain[STAGES-2:0], sf_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_last <= 1'b0;
      sf_last <= 1'b0;
    end else begin
      sc_last <= sc_chain[TOP];
      sf_last <= sf_chain[TOP];
    end
  end

  assign sc_fall  = sc_last & ~sc_chain[TOP];
  assign sc_rise  = ~sc_last & sc_chain[TOP];
  assign sf_edge  = sf_last ^ sf_chain[TOP];
  assign sf_level = sf_chain[TOP];

  // R9: a rising edge is never reported twice in a row
  a_r9_rise_single: assert property (@(posedge clk) disable iff (rst)
    sc_rise |=> !sc_rise);

endmodule

// File: rtl/tx_slot_ctrl.sv
module tx_slot_ctrl
  import audio_tx_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sf_edge,
  input  logic         sf_level,
  input  frame_e       mode,
  input  logic [W-1:0] left_in,
  input  logic [W-1:0] right_in,
  output logic [W-1:0] slot_word
);

  logic         is_left;
  logic         left_open;
  logic [W-1:0] right_hold;

  // Channel polarity depends on framing
  assign is_left   = (mode == FRAME_I2S) ? ~sf_level : sf_level;
  assign left_open = sf_edge & is_left;

  // The left word is used in the cycle its slot opens, so only the right one needs storage
  always_ff @(posedge clk) begin
    if (rst) right_hold <= '0;
    else if (left_open) right_hold <= right_in;
  end

  assign slot_word = is_left ? left_in : right_hold;

  // R8: the stored right word moves only when a left slot opens
  a_r8_right_frozen: assert property (@(posedge clk) disable iff (rst)
    !left_open |=> $stable(right_hold));

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sc_fall,
  input  logic         sf_edge,
  input  logic         i2s,
  input  logic [W-1:0] word,
  output logic         sdout
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] sent_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      sdout    <= 1'b0;
      sent_cnt <= '0;
    end else if (sf_edge) begin
      if (!i2s) begin
        // Left-justified: MSB goes out with the channel transition
        sdout    <= word[W-1];
        shreg    <= {word[W-2:0], 1'b0};
        sent_cnt <= CW'(1);
      end else begin
        // I2S: a coincident falling edge still finishes the old slot
        if (sc_fall) sdout <= shreg[W-1];
        shreg    <= word;
        sent_cnt <= '0;
      end
    end else if (sc_fall) begin
      sdout <= shreg[W-1];
      shreg <= {shreg[W-2:0], 1'b0};
      if (sent_cnt != CW'(W)) sent_cnt <= sent_cnt + 1'b1;
    end
  end

  // R9: the output is quiet unless a falling edge or a channel transition occurred
  a_r9_quiet_between_edges: assert property (@(posedge clk) disable iff (rst)
    (!sc_fall && !sf_edge) |=> $stable(sdout));

  // R3: left-justified slot opens with the word's MSB
  a_r3_lj_msb_on_sf: assert property (@(posedge clk) disable iff (rst)
    (sf_edge && !i2s) |=> (sdout == $past(word[W-1])));

  // R4: in I2S the transition alone does not move the output
  a_r4_i2s_delay: assert property (@(posedge clk) disable iff (rst)
    (sf_edge && i2s && !sc_fall) |=> $stable(sdout));

  // R7: once all data bits have left, the tail is zero
  a_r7_zero_tail: assert property (@(posedge clk) disable iff (rst)
    (sc_fall && !sf_edge && (sent_cnt == CW'(W))) |=> !sdout);

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int W           = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sc_in,
  input  logic         sf_in,
  input  logic [1:0]   fmt_sel,
  input  logic [W-1:0] left_smp,
  input  logic [W-1:0] right_smp,
  output logic         sdout
);

  frame_e       mode;
  logic         sc_fall;
  logic         sc_rise;
  logic         sf_edge;
  logic         sf_level;
  logic [W-1:0] slot_word;

  assign mode = decode_frame(fmt_sel);

  tx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sc_in    (sc_in),
    .sf_in    (sf_in),
    .sc_fall  (sc_fall),
    .sc_rise  (sc_rise),
    .sf_edge  (sf_edge),
    .sf_level (sf_level)
  );

  tx_slot_ctrl #(.W(W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .sf_edge   (sf_edge),
    .sf_level  (sf_level),
    .mode      (mode),
    .left_in   (left_smp),
    .right_in  (right_smp),
    .slot_word (slot_word)
  );

  tx_shifter #(.W(W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sc_fall (sc_fall),
    .sf_edge (sf_edge),
    .i2s     (mode == FRAME_I2S),
    .word    (slot_word),
    .sdout   (sdout)
  );

  // R9: the output never moves in the cycle after a rising bit-clock edge alone
  a_r9_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    (sc_rise && !sf_edge) |=> $stable(sdout));

endmodule

// File: tb/audio_serial_tx_test.sv
module audio_serial_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sc_in = 1'b1;
  logic        sf_in = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic [23:0] left_smp = '0;
  logic [23:0] right_smp = '0;
  logic        sdout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state kept by the bench
  logic [23:0] ref_right = '0;
  logic        ref_carry = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_tx uut (
    .clk(clk), .rst(rst), .sc_in(sc_in), .sf_in(sf_in),
    .fmt_sel(fmt_sel), .left_smp(left_smp), .right_smp(right_smp),
    .sdout(sdout)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (sdout !== exp) begin
      errors++;
      $display("FAIL %s at %0t: sdout actual=%b expected=%b", req, $time, sdout, exp);
    end
  endtask

  // One slot of n bit clocks at channel level lvl; optional mid-slot sample write
  task automatic run_slot(input int n, input logic lvl, input bit midw,
                          input logic [23:0] ml, input logic [23:0] mr);
    bit          i2s;
    bit          is_left;
    logic [23:0] w;
    logic        e;
    i2s     = (fmt_sel == 2'b01);
    is_left = i2s ? (lvl == 1'b0) : (lvl == 1'b1);
    if (is_left) begin
      ref_right = right_smp;
      w = left_smp;
    end else begin
      w = ref_right;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sc_in = 1'b0;
      if (k == 0) sf_in = lvl;
      if (midw && k == n/2) begin
        left_smp  = ml;
        right_smp = mr;
      end
      if (i2s) begin
        if (k == 0) e = ref_carry;
        else        e = (k <= 24) ? w[24-k] : 1'b0;
      end else begin
        e = (k < 24) ? w[23-k] : 1'b0;
      end
      repeat (HALF - 1) @(negedge clk);
      // R3 R4 R5 R6 R7 R8 R10: expected bit just before the rising edge
      check(i2s ? "R4/R5/R6/R7/R8/R10" : "R3/R5/R6/R7/R8", e);
      sc_in = 1'b1;
      repeat (HALF) @(negedge clk);
      // R9: unchanged across the rising edge
      check("R9", e);
    end
    ref_carry = (i2s && n <= 24) ? w[24-n] : 1'b0;
  endtask

  task automatic run_frame(input int n, input bit midw,
                           input logic [23:0] ml, input logic [23:0] mr);
    logic left_lvl;
    left_lvl = (fmt_sel == 2'b01) ? 1'b0 : 1'b1;
    if (sf_in == left_lvl) run_slot(n, ~left_lvl, 0, '0, '0);
    run_slot(n, left_lvl, midw, ml, mr);
    run_slot(n, ~left_lvl, 0, '0, '0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R1", 1'b0);

    // R2 code 00 left-justified, wide slot and exact slot
    fmt_sel = 2'b00; left_smp = 24'h800001; right_smp = 24'h7FFFFE;
    run_frame(32, 0, '0, '0);
    left_smp = 24'hA5C3F0; right_smp = 24'h0F1E2D;
    run_frame(24, 0, '0, '0);

    // R2 code 01 I2S, wide then exact-fit slots (R10)
    fmt_sel = 2'b01; left_smp = 24'hFFFFFF; right_smp = 24'h000001;
    run_frame(32, 0, '0, '0);
    left_smp = 24'h123457; right_smp = 24'hC0FFEE;
    run_frame(24, 0, '0, '0);
    left_smp = 24'h800000; right_smp = 24'h7FFFFF;
    run_frame(24, 0, '0, '0);

    // R8 mid-frame write in I2S
    left_smp = 24'h3C3C3C; right_smp = 24'hE1E1E1;
    run_frame(32, 1, 24'h5A5A5A, 24'h969696);
    run_frame(32, 0, '0, '0);

    // R2 code 10 left-justified with mid-frame write (R8)
    fmt_sel = 2'b10; left_smp = 24'h00FF00; right_smp = 24'hFF00FF;
    run_frame(32, 1, 24'hABCDEF, 24'h654321);
    run_frame(32, 0, '0, '0);

    // R2 code 11 treated as left-justified, odd slot length
    fmt_sel = 2'b11; left_smp = 24'hDEADBE; right_smp = 24'h2468AC;
    run_frame(25, 0, '0, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule